// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching page-table entries from memory for a two-level, 32-bit virtual addressing scheme. A miss request carries the 20-bit virtual page number, the kind of access (load, store or fetch), whether the requester runs in user or supervisor mode, and the two status controls. One control lets supervisor code touch user pages, and the other lets loads read execute-only pages. The root table's physical page number is sampled from a plain input when the request is accepted. The walker then issues word reads on a request/response memory port. It finishes at level 1 with a 4 MiB megapage, or it follows a pointer and finishes at level 0 with a 4 KiB page.

The outcome is a single-cycle pulse, `done_o` for a translation or `fault_o` for a page fault. With the pulse come the last entry read, the level it was read at, and a fault cause. The cause tells an unallocated level apart from each kind of bad leaf. A translation-fill unit consumes these outputs. Only one walk is in flight at a time.

Back-pressure rules: the miss port is valid/ready, and `req_ready_o` is high only while the walker is idle. Once `mem_req_valid_o` rises, it and `mem_req_addr_o` hold until `mem_req_ready_i` is seen high at a clock edge. The response is taken in a cycle where both `mem_rsp_valid_i` and `mem_rsp_ready_o` are high. The result pulse cannot be stalled.

Top module: `sv32_page_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o`=1, and `mem_req_valid_o`, `mem_rsp_ready_o`, `done_o` and `fault_o` are all 0.
- R2: A miss is accepted only on a cycle with `req_valid_i` and `req_ready_o` both high. `req_ready_o` stays low from acceptance until the result pulse has ended, and miss inputs that change meanwhile have no effect on the walk.
- R3: The first read address is root PPN × 4096 + VPN[19:10] × 4.
- R4: An entry is laid out as V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, A=bit6, D=bit7, PPN=bits[31:10]. An entry with V=1 and R=W=X=0 read at level 1 is a pointer. The walk then reads address PPN × 4096 + VPN[9:0] × 4 at level 0.
- R5: While `mem_req_ready_i` is low, `mem_req_valid_o` stays high and `mem_req_addr_o` stays unchanged.
- R6: A leaf that passes all checks yields `done_o`, the leaf entry and its level. A level-1 leaf takes one read; a level-0 leaf takes two reads.
- R7: An entry with V=0 faults with cause 1 at level 1 (table not allocated) and cause 2 at level 0.
- R8: A valid entry with W=1 and R=0 faults with cause 3. A pointer read at level 0 faults with cause 4.
- R9: A level-1 leaf whose PPN bits [9:0] are not all zero faults with cause 5.
- R10: Cause 6 covers two privilege errors. One is a user-mode access to an entry with U=0. The other is a supervisor access to an entry with U=1 that is either a fetch or a data access with the user-access control clear.
- R11: Cause 7 is raised when a load finds neither R nor (X with the execute-readable control set), when a store finds W=0, or when a fetch finds X=0. Access codes are load=0, store=1, fetch=2.
- R12: A leaf with A=0 faults with cause 8. A store to a leaf with D=0 faults with cause 9.
- R13: Causes are ranked 1/2, 3, 4, 5, 6, 7, 8, 9, and the lowest applicable one is reported. Each walk ends with exactly one single-cycle pulse of `done_o` or `fault_o`, which carries the entry and level last read. On `done_o` the cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vpn_i | input | 20 | Virtual page number of the miss |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_sum_i | input | 1 | Supervisor may access user pages |
| req_mxr_i | input | 1 | Loads may read execute-only pages |
| satp_ppn_i | input | 22 | Root table physical page number |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 34 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker waiting for read data |
| mem_rsp_data_i | input | 32 | Entry word read |
| done_o | output | 1 | Translation found (one cycle) |
| fault_o | output | 1 | Page fault (one cycle) |
| res_pte_o | output | 32 | Last entry read |
| res_level_o | output | 1 | Level of that entry |
| res_cause_o | output | 4 | Fault cause, 0 on success |

## Verification
The main coincidence is several fault conditions present on the same leaf word in the same evaluation cycle. Examples are a missing accessed bit together with a store permission denial and a privilege mismatch, or a misaligned megapage that is also unreadable. Only the ranked cause may appear. Every 8-bit flag pattern is swept at both levels, across all access kinds, modes and control settings. Each reported cause is compared with the ranking computed in the bench. A second coincidence is a new miss request arriving while a walk is in flight and the memory is stalling: it is provoked by holding `req_valid_i` high with altered fields, and is judged by unchanged read addresses and results.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [3:0] {
    CS_NONE     = 4'd0,
    CS_NOMAP_L1 = 4'd1,
    CS_NOMAP_L0 = 4'd2,
    CS_RESERVED = 4'd3,
    CS_PTR_L0   = 4'd4,
    CS_MISALIGN = 4'd5,
    CS_PRIV     = 4'd6,
    CS_PERM     = 4'd7,
    CS_NO_ACC   = 4'd8,
    CS_NO_DIRTY = 4'd9
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_L1, ST_WAIT_L1, ST_REQ_L0, ST_WAIT_L0, ST_DONE, ST_FAULT
  } state_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int PPN_W    = 22,
  parameter int SEG_W    = 10,
  parameter int LEVELS   = 2,
  parameter int ENTRY_LG = 2,
  localparam int VPN_W   = SEG_W * LEVELS,
  localparam int PA_W    = PPN_W + SEG_W + ENTRY_LG
) (
  input  logic             lvl_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic [PPN_W-1:0] next_ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [SEG_W-1:0] seg [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_seg
    assign seg[g] = vpn_i[g*SEG_W +: SEG_W];
  end

  logic [PPN_W-1:0] base;
  assign base   = lvl_i ? root_ppn_i : next_ppn_i;
  assign addr_o = {base, seg[lvl_i], {ENTRY_LG{1'b0}}};
endmodule

// File: rtl/pgwalk_check.sv
module pgwalk_check
  import pgwalk_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int SEG_W = 10,
  parameter int PPN_W = 22
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             lvl_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic             sum_i,
  input  logic             mxr_i,
  output logic             descend_o,
  output logic             fault_o,
  output cause_e           cause_o
);
  logic v, r, w, x, u, a, d, leaf, fetch, store, load, perm_ok, priv_bad;
  logic [PPN_W-1:0] ppn;
  logic unused_bits;

  assign v     = pte_i[BIT_V];
  assign r     = pte_i[BIT_R];
  assign w     = pte_i[BIT_W];
  assign x     = pte_i[BIT_X];
  assign u     = pte_i[BIT_U];
  assign a     = pte_i[BIT_A];
  assign d     = pte_i[BIT_D];
  assign ppn   = pte_i[PTE_W-1 -: PPN_W];
  assign unused_bits = ^{pte_i[PTE_W-PPN_W-1:BIT_D+1], pte_i[5]};
  assign leaf  = r | x;
  assign load  = (acc_i == ACC_LOAD);
  assign store = (acc_i == ACC_STORE);
  assign fetch = !load && !store;

  always_comb begin
    if (load)       perm_ok = r | (x & mxr_i);
    else if (store) perm_ok = w;
    else            perm_ok = x;
  end

  assign priv_bad = user_i ? !u : (u && (fetch || !sum_i));

  always_comb begin
    cause_o = CS_NONE;
    if (!v)                                  cause_o = lvl_i ? CS_NOMAP_L1 : CS_NOMAP_L0;
    else if (w && !r)                        cause_o = CS_RESERVED;
    else if (!leaf && !lvl_i)                cause_o = CS_PTR_L0;
    else if (!leaf)                          cause_o = CS_NONE;
    else if (lvl_i && ppn[SEG_W-1:0] != '0)  cause_o = CS_MISALIGN;
    else if (priv_bad)                       cause_o = CS_PRIV;
    else if (!perm_ok)                       cause_o = CS_PERM;
    else if (!a)                             cause_o = CS_NO_ACC;
    else if (store && !d)                    cause_o = CS_NO_DIRTY;
  end

  assign fault_o   = (cause_o != CS_NONE);
  assign descend_o = !fault_o && !leaf;
endmodule

// File: rtl/sv32_page_walker.sv
module sv32_page_walker
  import pgwalk_pkg::*;
#(
  parameter int PPN_W    = 22,
  parameter int SEG_W    = 10,
  parameter int PTE_W    = 32,
  parameter int ENTRY_LG = 2,
  localparam int LEVELS  = 2,
  localparam int VPN_W   = SEG_W * LEVELS,
  localparam int PA_W    = PPN_W + SEG_W + ENTRY_LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic             req_sum_i,
  input  logic             req_mxr_i,
  input  logic [PPN_W-1:0] satp_ppn_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  output logic             mem_rsp_ready_o,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [PTE_W-1:0] res_pte_o,
  output logic             res_level_o,
  output logic [3:0]       res_cause_o
);
  state_e           state;
  logic [VPN_W-1:0] vpn_q;
  logic [1:0]       acc_q;
  logic             user_q, sum_q, mxr_q, lvl_q;
  logic [PPN_W-1:0] root_q, next_q;
  logic [PTE_W-1:0] pte_q;
  cause_e           cause_q;

  logic   chk_descend, chk_fault;
  cause_e chk_cause;

  pgwalk_addr #(.PPN_W(PPN_W), .SEG_W(SEG_W), .LEVELS(LEVELS), .ENTRY_LG(ENTRY_LG)) u_addr (
    .lvl_i      (lvl_q),
    .root_ppn_i (root_q),
    .next_ppn_i (next_q),
    .vpn_i      (vpn_q),
    .addr_o     (mem_req_addr_o)
  );

  pgwalk_check #(.PTE_W(PTE_W), .SEG_W(SEG_W), .PPN_W(PPN_W)) u_check (
    .pte_i     (mem_rsp_data_i),
    .lvl_i     (lvl_q),
    .acc_i     (acc_q),
    .user_i    (user_q),
    .sum_i     (sum_q),
    .mxr_i     (mxr_q),
    .descend_o (chk_descend),
    .fault_o   (chk_fault),
    .cause_o   (chk_cause)
  );

  logic waiting;
  assign waiting = (state == ST_WAIT_L1) || (state == ST_WAIT_L0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vpn_q   <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      lvl_q   <= 1'b1;
      root_q  <= '0;
      next_q  <= '0;
      pte_q   <= '0;
      cause_q <= CS_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vpn_i;
          acc_q   <= req_acc_i;
          user_q  <= req_user_i;
          sum_q   <= req_sum_i;
          mxr_q   <= req_mxr_i;
          root_q  <= satp_ppn_i;
          lvl_q   <= 1'b1;
          cause_q <= CS_NONE;
          state   <= ST_REQ_L1;
        end
        ST_REQ_L1: if (mem_req_ready_i) state <= ST_WAIT_L1;
        ST_REQ_L0: if (mem_req_ready_i) state <= ST_WAIT_L0;
        ST_WAIT_L1, ST_WAIT_L0: if (mem_rsp_valid_i) begin
          pte_q <= mem_rsp_data_i;
          if (chk_fault) begin
            cause_q <= chk_cause;
            state   <= ST_FAULT;
          end else if (chk_descend) begin
            next_q <= mem_rsp_data_i[PTE_W-1 -: PPN_W];
            lvl_q  <= 1'b0;
            state  <= ST_REQ_L0;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE, ST_FAULT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign mem_req_valid_o = (state == ST_REQ_L1) || (state == ST_REQ_L0);
  assign mem_rsp_ready_o = waiting;
  assign done_o          = (state == ST_DONE);
  assign fault_o         = (state == ST_FAULT);
  assign res_pte_o       = pte_q;
  assign res_level_o     = lvl_q;
  assign res_cause_o     = cause_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_req_valid_o && !mem_rsp_ready_o && !done_o && !fault_o); // R2
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |=> !done_o && !fault_o && req_ready_o); // R13
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> res_cause_o == 4'd0 && res_pte_o[BIT_A] && res_pte_o[BIT_V]); // R12
  AST_MEGA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && res_level_o |-> res_pte_o[PTE_W-PPN_W +: SEG_W] == '0); // R9
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> res_cause_o != 4'd0); // R13
  AST_L0_PTR_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !res_level_o |-> (res_pte_o[BIT_R] || res_pte_o[BIT_X])); // R8
endmodule

// File: tb/sv32_page_walker_bench.sv
module sv32_page_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [19:0] req_vpn_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_user_i = 1'b0, req_sum_i = 1'b0, req_mxr_i = 1'b0;
  logic [21:0] satp_ppn_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [33:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i = '0;
  logic        done_o, fault_o;
  logic [31:0] res_pte_o;
  logic        res_level_o;
  logic [3:0]  res_cause_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sv32_page_walker u_sv32_page_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vpn_i(req_vpn_i),
    .req_acc_i(req_acc_i), .req_user_i(req_user_i), .req_sum_i(req_sum_i),
    .req_mxr_i(req_mxr_i), .satp_ppn_i(satp_ppn_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_ready_o(mem_rsp_ready_o), .mem_rsp_data_i(mem_rsp_data_i),
    .done_o(done_o), .fault_o(fault_o), .res_pte_o(res_pte_o),
    .res_level_o(res_level_o), .res_cause_o(res_cause_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      0:       return "R6";
      1, 2:    return "R7";
      3, 4:    return "R8";
      5:       return "R9";
      6:       return "R10";
      7:       return "R11";
      default: return "R12";
    endcase
  endfunction

  // Ranked cause per R7..R13; -1 means a pointer at level 1 (R4)
  function automatic int leaf_cause(input logic [31:0] p, input int lvl, input logic [1:0] acc,
                                    input logic usr, input logic sm, input logic mx);
    logic ok;
    if (!p[0]) return (lvl == 1) ? 1 : 2;
    if (p[2] && !p[1]) return 3;
    if (!p[1] && !p[3]) return (lvl == 1) ? -1 : 4;
    if (lvl == 1 && p[19:10] != 10'd0) return 5;
    if (usr ? !p[4] : (p[4] && (acc == 2'd2 || !sm))) return 6;
    ok = (acc == 2'd0) ? (p[1] | (p[3] & mx)) : (acc == 2'd1) ? p[2] : p[3];
    if (!ok) return 7;
    if (!p[6]) return 8;
    if (acc == 2'd1 && !p[7]) return 9;
    return 0;
  endfunction

  task automatic do_walk(input logic [19:0] vpn, input logic [21:0] root, input logic [1:0] acc,
                         input logic usr, input logic sm, input logic mx,
                         input logic [31:0] l1, input logic [31:0] l0,
                         input int stall, input bit poke);
    int c1, ecause, elvl, enreads, nreads, st;
    logic [31:0] epte;
    logic [33:0] a1, a0, ea;
    bit got, pending;
    a1 = {root, vpn[19:10], 2'b00};
    a0 = {l1[31:10], vpn[9:0], 2'b00};
    c1 = leaf_cause(l1, 1, acc, usr, sm, mx);
    if (c1 == -1) begin
      ecause = leaf_cause(l0, 0, acc, usr, sm, mx); elvl = 0; epte = l0; enreads = 2;
    end else begin
      ecause = c1; elvl = 1; epte = l1; enreads = 1;
    end

    @(negedge clk);
    chk(req_ready_o == 1'b1, "R2", "ready before walk", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_vpn_i = vpn; req_acc_i = acc;
    req_user_i = usr; req_sum_i = sm; req_mxr_i = mx; satp_ppn_i = root;
    @(posedge clk); #1;
    if (poke) begin
      req_vpn_i = ~vpn; satp_ppn_i = ~root; req_acc_i = acc ^ 2'd1; req_user_i = ~usr;
    end else req_valid_i = 1'b0;

    nreads = 0; pending = 0; st = stall; got = 0;
    for (int c = 0; c < 64 && !got; c++) begin
      @(negedge clk);
      mem_req_ready_i = 1'b0;
      mem_rsp_valid_i = 1'b0;
      if (done_o || fault_o) begin
        got = 1;
        req_valid_i = 1'b0;
        chk(done_o == (ecause == 0) && fault_o == (ecause != 0), tag_of(ecause), "outcome",
            64'({done_o, fault_o}), 64'({ecause == 0, ecause != 0}));
        chk(res_cause_o == 4'(ecause), tag_of(ecause), "cause", 64'(res_cause_o), 64'(ecause));
        chk(res_level_o == elvl[0], "R13", "level", 64'(res_level_o), 64'(elvl));
        chk(res_pte_o == epte, "R13", "entry", 64'(res_pte_o), 64'(epte));
      end else begin
        chk(req_ready_o == 1'b0, "R2", "ready while busy", 64'(req_ready_o), 64'd0);
        if (mem_req_valid_o) begin
          ea = (nreads == 0) ? a1 : a0;
          chk(nreads < 2 && mem_req_addr_o == ea, (st > 0) ? "R5" : (nreads == 0) ? "R3" : "R4",
              "read address", 64'(mem_req_addr_o), 64'(ea));
          if (st > 0) st--;
          else begin
            mem_req_ready_i = 1'b1; nreads++; pending = 1;
          end
        end else if (pending && mem_rsp_ready_o) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i = (nreads == 1) ? l1 : l0;
          pending = 0;
        end
      end
    end
    chk(got, "R13", "walk finished", 64'(got), 64'd1);
    chk(nreads == enreads, "R6", "read count", 64'(nreads), 64'(enreads));
    @(negedge clk);
    chk(!done_o && !fault_o && req_ready_o, "R13", "single pulse then idle",
        64'({done_o, fault_o, req_ready_o}), 64'b001);
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready_o && !mem_req_valid_o && !mem_rsp_ready_o && !done_o && !fault_o, "R1",
        "reset state", 64'({req_ready_o, mem_req_valid_o, mem_rsp_ready_o, done_o, fault_o}),
        64'b10000);
    rst_n = 1'b1;
    for (int lv = 1; lv >= 0; lv--) begin
      for (int f = 0; f < 256; f++) begin
        for (int a = 0; a < 3; a++) begin
          for (int m = 0; m < 8; m++) begin
            logic [31:0] l1, l0;
            logic [21:0] ppn;
            if (lv == 1) begin
              ppn = (k % 5 == 0) ? {12'(k * 7 + 1), 10'(k | 1)} : {12'(k * 7 + 1), 10'd0};
              l1 = {ppn, 2'b00, 8'(f)};
              l0 = {22'(k * 3 + 9), 2'b00, 8'hDF};
            end else begin
              l1 = {22'(k * 131 + 5), 2'b11, 8'h01};
              l0 = {22'(k * 29 + 1), 2'b00, 8'(f)};
            end
            do_walk(20'(k * 40503 + 7), 22'(k * 977 + 3), 2'(a), m[0], m[1], m[2],
                    l1, l0, (k % 4 == 0) ? 2 : 0, (k % 3 == 1));
            k++;
          end
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R13 watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule